// File: doc/BRIEF.md
# Per-Channel Threshold Window and Crossing Detector

This block sits after a multi-channel converter and inspects every finished conversion. A result arrives as a single-cycle strobe carrying a channel number and a 12-bit unsigned value. The block picks one of two shared low/high threshold pairs for that channel. It reports whether the value lies inside, below or above the window. It also reports whether the value has crossed the pair's low threshold since the previous result on the same channel.

Each channel has a 2-bit interrupt mode. The mode decides whether a value outside the window sets that channel's event flag, whether a crossing sets it, or whether neither does. Software clears the flags by writing ones. An aggregate interrupt stays asserted while any flag is set. Thresholds, the per-channel pair selection and the mode fields are loaded through a small register write port.

Top module: `thr_window_detector`

## Requirements
- R1: `stat_range` reports 0 when low <= value <= high, 1 when value < low and 2 when value > high. Both bounds are inclusive and are compared as unsigned numbers.
- R2: Bit n of the pair-select register (select code 4, data bits 0..11) picks pair 0 (bit clear) or pair 1 (bit set) for channel n. Select codes 0 and 1 load the low and high values of pair 0. Codes 2 and 3 load the low and high values of pair 1 (data bits 11:0).
- R3: `stat_cross` is 2 when the previous sample on the channel was at or above the selected low threshold and the current one is below it. It is 3 for the reverse direction and 0 otherwise. Only the low threshold takes part.
- R4: After reset a channel has no previous sample, so its first conversion reports crossing code 0.
- R5: The mode register (select code 5) holds channel n's mode in data bits 2n+4:2n+3. Mode 1 sets flag n when the range code is not 0.
- R6: Mode 2 sets flag n when the crossing code is not 0. Modes 0 and 3 never set a flag.
- R7: Flags sit in `flag_word` bits 0..11. Writing 1 to a bit of `clr_mask` with `clr_we` clears that flag and leaves the other flags unchanged. A flag that is set and cleared in the same cycle stays set.
- R8: `thr_irq` and `flag_word` bit 30 are high exactly while at least one flag is set.
- R9: The status outputs and flags update on the clock edge that samples `res_valid`. A strobe with a channel number of 12 or more produces no status, no flag and no change to any channel's history.
- R10: After reset both low thresholds are 0, both high thresholds are 4095, all pair selects and modes are 0, and all flags and `stat_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | 4 | Channel number of the result |
| res_val | input | 12 | Conversion value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select (0..5) |
| cfg_wdata | input | 32 | Configuration write data |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 32 | Write-one-to-clear mask, bits 0..11 |
| stat_valid | output | 1 | Status outputs hold a fresh result |
| stat_ch | output | 4 | Channel of the reported result |
| stat_range | output | 2 | Window classification code |
| stat_cross | output | 2 | Crossing classification code |
| flag_word | output | 32 | Per-channel flags in bits 0..11, aggregate in bit 30 |
| thr_irq | output | 1 | Aggregate threshold interrupt |

## Verification
The bench builds the block with its default twelve channels and a 4-bit channel field. This leaves channel codes 12 to 15 reachable, so the ignored-channel rule can be tested. Directed cases cover values at and next to both bounds, the first sample after reset, both crossing directions, all four mode codes, and a set that coincides with a clear. Random traffic then mixes channels, pairs, thresholds and modes against a bench model of each channel's history.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int unsigned DW = 12;

    typedef enum logic [1:0] {
        RNG_IN    = 2'd0,
        RNG_BELOW = 2'd1,
        RNG_ABOVE = 2'd2
    } range_e;

    typedef enum logic [1:0] {
        XING_NONE = 2'd0,
        XING_DOWN = 2'd2,
        XING_UP   = 2'd3
    } xing_e;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_OUTSIDE = 2'd1,
        MODE_XING    = 2'd2
    } irq_mode_e;

    localparam logic [2:0] SEL_P0_LO = 3'd0;
    localparam logic [2:0] SEL_P0_HI = 3'd1;
    localparam logic [2:0] SEL_P1_LO = 3'd2;
    localparam logic [2:0] SEL_P1_HI = 3'd3;
    localparam logic [2:0] SEL_PAIR  = 3'd4;
    localparam logic [2:0] SEL_MODE  = 3'd5;

    localparam int unsigned MODE_LSB = 3;
    localparam int unsigned AGG_BIT  = 30;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs #(
    parameter int unsigned NCH = 12,
    parameter int unsigned DW  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [31:0]      wdata,
    output logic [DW-1:0]    lo0,
    output logic [DW-1:0]    hi0,
    output logic [DW-1:0]    lo1,
    output logic [DW-1:0]    hi1,
    output logic [NCH-1:0]   pair_sel,
    output logic [2*NCH-1:0] modes
);
    import thr_pkg::*;

    typedef struct packed {
        logic [DW-1:0]    lo0;
        logic [DW-1:0]    hi0;
        logic [DW-1:0]    lo1;
        logic [DW-1:0]    hi1;
        logic [NCH-1:0]   psel;
        logic [2*NCH-1:0] mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                SEL_P0_LO: cfg_d.lo0  = wdata[DW-1:0];
                SEL_P0_HI: cfg_d.hi0  = wdata[DW-1:0];
                SEL_P1_LO: cfg_d.lo1  = wdata[DW-1:0];
                SEL_P1_HI: cfg_d.hi1  = wdata[DW-1:0];
                SEL_PAIR:  cfg_d.psel = wdata[NCH-1:0];
                SEL_MODE:  cfg_d.mode = wdata[MODE_LSB +: 2*NCH];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lo0  <= '0;
            cfg_q.hi0  <= '1;
            cfg_q.lo1  <= '0;
            cfg_q.hi1  <= '1;
            cfg_q.psel <= '0;
            cfg_q.mode <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lo0      = cfg_q.lo0;
    assign hi0      = cfg_q.hi0;
    assign lo1      = cfg_q.lo1;
    assign hi1      = cfg_q.hi1;
    assign pair_sel = cfg_q.psel;
    assign modes    = cfg_q.mode;
endmodule

// File: rtl/thr_classify.sv
module thr_classify #(
    parameter int unsigned DW = 12
) (
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          have_prev,
    input  logic          prev_below,
    output logic [1:0]    range_code,
    output logic [1:0]    xing_code,
    output logic          now_below
);
    import thr_pkg::*;

    always_comb begin
        now_below = (value < lo);
        if (now_below)
            range_code = RNG_BELOW;
        else if (value > hi)
            range_code = RNG_ABOVE;
        else
            range_code = RNG_IN;

        xing_code = XING_NONE;
        if (have_prev && (prev_below != now_below))
            xing_code = now_below ? XING_DOWN : XING_UP;
    end
endmodule

// File: rtl/thr_window_detector.sv
module thr_window_detector #(
    parameter int unsigned NCH = 12,
    parameter int unsigned DW  = 12,
    parameter int unsigned CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           res_valid,
    input  logic [CHW-1:0] res_ch,
    input  logic [DW-1:0]  res_val,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic           clr_we,
    input  logic [31:0]    clr_mask,
    output logic           stat_valid,
    output logic [CHW-1:0] stat_ch,
    output logic [1:0]     stat_range,
    output logic [1:0]     stat_cross,
    output logic [31:0]    flag_word,
    output logic           thr_irq
);
    import thr_pkg::*;

    logic [DW-1:0]    lo0, hi0, lo1, hi1;
    logic [NCH-1:0]   pair_sel;
    logic [2*NCH-1:0] modes;

    thr_cfg_regs #(.NCH(NCH), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1),
        .pair_sel(pair_sel), .modes(modes)
    );

    typedef struct packed {
        logic           sv;
        logic [CHW-1:0] ch;
        logic [1:0]     rng;
        logic [1:0]     xg;
        logic [NCH-1:0] flags;
        logic [NCH-1:0] have_prev;
        logic [NCH-1:0] prev_below;
        logic           irq;
    } st_t;

    st_t st_d, st_q;

    logic           ch_ok;
    logic [CHW-1:0] idx;
    logic [DW-1:0]  sel_lo, sel_hi;
    logic [1:0]     rng_c, xg_c, mode_c;
    logic           below_c;

    assign ch_ok  = ({1'b0, res_ch} < (CHW+1)'(NCH));
    assign idx    = ch_ok ? res_ch : '0;
    assign sel_lo = pair_sel[idx] ? lo1 : lo0;
    assign sel_hi = pair_sel[idx] ? hi1 : hi0;
    assign mode_c = modes[2*int'(idx) +: 2];

    thr_classify #(.DW(DW)) u_cls (
        .value(res_val), .lo(sel_lo), .hi(sel_hi),
        .have_prev(st_q.have_prev[idx]), .prev_below(st_q.prev_below[idx]),
        .range_code(rng_c), .xing_code(xg_c), .now_below(below_c)
    );

    always_comb begin
        logic [NCH-1:0] set_v;
        st_d    = st_q;
        set_v   = '0;
        st_d.sv = 1'b0;
        if (res_valid && ch_ok) begin
            st_d.sv               = 1'b1;
            st_d.ch               = res_ch;
            st_d.rng              = rng_c;
            st_d.xg               = xg_c;
            st_d.have_prev[idx]   = 1'b1;
            st_d.prev_below[idx]  = below_c;
            case (mode_c)
                MODE_OUTSIDE: set_v[idx] = (rng_c != RNG_IN);
                MODE_XING:    set_v[idx] = (xg_c != XING_NONE);
                default:      set_v[idx] = 1'b0;
            endcase
        end
        if (clr_we)
            st_d.flags = st_d.flags & ~clr_mask[NCH-1:0];
        st_d.flags = st_d.flags | set_v;
        st_d.irq   = |st_d.flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flag_word            = '0;
        flag_word[NCH-1:0]   = st_q.flags;
        flag_word[AGG_BIT]   = st_q.irq;
    end

    assign stat_valid = st_q.sv;
    assign stat_ch    = st_q.ch;
    assign stat_range = st_q.rng;
    assign stat_cross = st_q.xg;
    assign thr_irq    = st_q.irq;
endmodule

// File: rtl/thr_window_chk.sv
module thr_window_chk #(
    parameter int unsigned NCH = 12,
    parameter int unsigned CHW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           res_valid,
    input logic [CHW-1:0] res_ch,
    input logic           clr_we,
    input logic           stat_valid,
    input logic [CHW-1:0] stat_ch,
    input logic [1:0]     stat_range,
    input logic [1:0]     stat_cross,
    input logic [31:0]    flag_word,
    input logic           thr_irq
);
    logic ch_ok;
    assign ch_ok = ({1'b0, res_ch} < (CHW+1)'(NCH));

    p_range_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_range != 2'd3));

    p_cross_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_cross != 2'd1));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flag_word[NCH-1:0] & $past(flag_word[NCH-1:0])) == $past(flag_word[NCH-1:0])));

    p_agg_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_word[NCH-1:0] != '0) |-> (thr_irq && flag_word[30]));

    p_agg_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_word[NCH-1:0] == '0) |-> !thr_irq);

    p_bad_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !ch_ok) |=> !stat_valid);

    p_status_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ch_ok) |=> (stat_valid && stat_ch == $past(res_ch)));
endmodule

bind thr_window_detector thr_window_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
    .clr_we(clr_we), .stat_valid(stat_valid), .stat_ch(stat_ch),
    .stat_range(stat_range), .stat_cross(stat_cross),
    .flag_word(flag_word), .thr_irq(thr_irq)
);

// File: tb/tb_thr_window_detector.sv
module tb_thr_window_detector;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_ch = '0;
    logic [11:0] res_val = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_mask = '0;
    logic        stat_valid;
    logic [3:0]  stat_ch;
    logic [1:0]  stat_range, stat_cross;
    logic [31:0] flag_word;
    logic        thr_irq;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int        m_lo[2], m_hi[2];
    bit [11:0] m_psel;
    int        m_mode[NCH];
    bit        m_have[NCH], m_below[NCH];
    bit [11:0] m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_window_detector dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
        .res_val(res_val), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .clr_we(clr_we), .clr_mask(clr_mask), .stat_valid(stat_valid),
        .stat_ch(stat_ch), .stat_range(stat_range), .stat_cross(stat_cross),
        .flag_word(flag_word), .thr_irq(thr_irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_range(int v, int lo, int hi);
        if (v < lo) return 1;
        if (v > hi) return 2;
        return 0;
    endfunction

    task automatic cfg_write(int sel, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_lo[0] = data & 12'hFFF;
            1: m_hi[0] = data & 12'hFFF;
            2: m_lo[1] = data & 12'hFFF;
            3: m_hi[1] = data & 12'hFFF;
            4: m_psel  = 12'(data);
            5: for (int i = 0; i < NCH; i++) m_mode[i] = (data >> (2*i+3)) & 3;
            default: ;
        endcase
    endtask

    task automatic set_modes();
        int w = 0;
        for (int i = 0; i < NCH; i++) w |= (m_mode[i] & 3) << (2*i+3);
        cfg_write(5, w);
    endtask

    task automatic check_flags(string req);
        check({req, " flags"}, int'(flag_word[11:0]), int'(m_flags));
        check("R8 irq", int'(thr_irq), int'(m_flags != 0));
        check("R8 bit30", int'(flag_word[30]), int'(m_flags != 0));
    endtask

    // one conversion strobe, optionally with a simultaneous clear
    task automatic conv(int ch, int v, bit do_clr, int mask, string req);
        int p, r, x;
        bit b, setf;
        @(negedge clk);
        res_valid = 1'b1; res_ch = 4'(ch); res_val = 12'(v);
        clr_we = do_clr; clr_mask = 32'(mask);
        @(negedge clk);
        res_valid = 1'b0; clr_we = 1'b0;
        setf = 0;
        if (do_clr) m_flags &= ~12'(mask);
        if (ch < NCH) begin
            p = m_psel[ch];
            r = exp_range(v, m_lo[p], m_hi[p]);
            b = (v < m_lo[p]);
            x = 0;
            if (m_have[ch] && m_below[ch] != b) x = b ? 2 : 3;
            m_have[ch] = 1; m_below[ch] = b;
            if (m_mode[ch] == 1 && r != 0) setf = 1;
            if (m_mode[ch] == 2 && x != 0) setf = 1;
            if (setf) m_flags[ch] = 1'b1;
            check({req, " valid"}, int'(stat_valid), 1);
            check({req, " ch"}, int'(stat_ch), ch);
            check({req, " range R1"}, int'(stat_range), r);
            check({req, " cross R3"}, int'(stat_cross), x);
        end else begin
            check("R9 bad channel valid", int'(stat_valid), 0);
        end
        check_flags(req);
    endtask

    task automatic clear(int mask);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 32'(mask);
        @(negedge clk);
        clr_we = 1'b0;
        m_flags &= ~12'(mask);
        check_flags("R7 clear");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_lo[0] = 0; m_hi[0] = 4095; m_lo[1] = 0; m_hi[1] = 4095;
        m_psel = '0; m_flags = '0;
        for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_have[i] = 0; m_below[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset flags", int'(flag_word), 0);
        check("R10 reset irq", int'(thr_irq), 0);
        check("R10 reset valid", int'(stat_valid), 0);
        // R10: default window 0..4095 puts everything in range
        conv(5, 4095, 0, 0, "R10 default window");

        cfg_write(0, 12'h400);
        cfg_write(1, 12'h800);
        cfg_write(2, 12'h100);
        cfg_write(3, 12'hF00);
        // R4: first sample on channel 0 below low -> no crossing
        conv(0, 12'h3FF, 0, 0, "R4 first sample");
        conv(0, 12'h400, 0, 0, "R3 up at low bound");
        conv(0, 12'h800, 0, 0, "R1 at high bound");
        conv(0, 12'h801, 0, 0, "R1 above high");
        conv(0, 12'h3FF, 0, 0, "R3 down");
        conv(0, 12'h000, 0, 0, "R3 stay below");
        // R2: channel 1 uses pair 1
        cfg_write(4, 32'h0000_0002);
        conv(1, 12'h200, 0, 0, "R2 pair1 in range");
        conv(1, 12'hF01, 0, 0, "R2 pair1 above");
        conv(1, 12'h0FF, 0, 0, "R2 pair1 below down");
        // R5/R6 modes
        m_mode[2] = 1; m_mode[3] = 2; m_mode[4] = 3; m_mode[6] = 0;
        set_modes();
        conv(2, 12'h500, 0, 0, "R5 mode1 inside");
        conv(2, 12'h900, 0, 0, "R5 mode1 outside");
        conv(3, 12'h100, 0, 0, "R6 mode2 first");
        conv(3, 12'h900, 0, 0, "R6 mode2 up");
        conv(4, 12'h100, 0, 0, "R6 mode3 first");
        conv(4, 12'h900, 0, 0, "R6 mode3 never");
        conv(6, 12'hFFF, 0, 0, "R6 mode0 never");
        // R7: clear one flag, others kept
        clear(32'h0000_0004);
        clear(32'h0000_0000);
        // R7: set and clear in same cycle -> set wins
        conv(2, 12'hA00, 1, 32'h0000_0004, "R7 set beats clear");
        clear(32'h0000_0FFF);
        // R9: bad channel ignores history and flags
        m_mode[0] = 2; set_modes();
        conv(13, 12'hFFF, 0, 0, "R9 ignored");
        conv(12, 12'h000, 0, 0, "R9 ignored");
        conv(0, 12'h000, 0, 0, "R9 history kept");

        // random phase
        for (int it = 0; it < 600; it++) begin
            int k = $urandom_range(0, 19);
            if (k == 0) cfg_write($urandom_range(0, 3), $urandom_range(0, 4095));
            else if (k == 1) cfg_write(4, $urandom_range(0, 4095));
            else if (k == 2) begin
                for (int i = 0; i < NCH; i++) m_mode[i] = $urandom_range(0, 3);
                set_modes();
            end else if (k == 3) clear($urandom_range(0, 4095));
            else conv($urandom_range(0, 15), $urandom_range(0, 4095),
                      ($urandom_range(0, 7) == 0), $urandom_range(0, 4095), "R1 R3 R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule